// File: doc/BRIEF.md
# Station Address Register and Destination Matcher

This block stores the 48-bit station address of a network port in two 32-bit host registers, a low word and a high word. The host writes and reads them through a simple register port with per-byte enables. The full address is always presented on the host side so that the transmit logic can use it as the source address of flow-control frames.

The block also carries a copy of the address into the receive clock domain. There it checks the destination address of each incoming frame against that copy. A host write to one particular byte of the low word starts the transfer. Which byte this is depends on a static endianness selection. The rest of the register writes only change the host copy.

On the receive side, the six destination bytes arrive one per accepted beat, and the first beat carries a start-of-frame flag. The bytes are packed least-significant byte first and compared with the receive-domain copy. A one-cycle match pulse follows the sixth byte.

The receive stream uses valid/ready. The block never applies back-pressure: `rx_ready` is held high outside reset, and a byte transfers on every cycle in which `rx_valid` is high.

Top module: `sta_addr_filter`

## Requirements
- R1: After reset the low word reads 0xFFFFFFFF and high word bits [15:0] read 0xFFFF. A write to the low word (host_sel=0) or the high word (host_sel=1) changes only the bytes whose host_be bit is set. A cycle without host_wr leaves both words unchanged.
- R2: The high word always reads bit 31 as 1 and bits [30:16] as 0. Writes to those bits have no effect.
- R3: From the cycle after a write, tx_src_addr equals {high[15:0], low[31:0]}.
- R4: The first received destination byte is compared with address bits [7:0]. Byte k is compared with bits [8k+7:8k]. For example, the bytes 11,22,33,44,55,66 match a stored address of 0x665544332211.
- R5: With cfg_big_endian=0, only a low-word write with host_be[3] set updates the receive-domain copy. Writes to other low bytes, and writes to the high word, leave matching unchanged.
- R6: With cfg_big_endian=1, only a low-word write with host_be[0] set updates the receive-domain copy.
- R7: The receive-domain copy resets to all ones. An update takes the complete 48-bit address as it stands after the triggering write. The update is in use within 8 receive cycles, provided triggering writes are at least 4 receive cycles apart.
- R8: rx_match is high for exactly one cycle, the cycle after the sixth byte is accepted, and only when all 48 bits are equal.
- R9: A new start-of-frame before the sixth byte restarts the compare, and the shortened frame produces no match. Bytes after the sixth, or bytes without a preceding start-of-frame, are ignored.
- R10: rx_ready is high outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host and transmit domain clock |
| hrst_n | input | 1 | Host domain reset, active low |
| host_wr | input | 1 | Register write strobe |
| host_sel | input | 1 | Write target: 0 low word, 1 high word |
| host_be | input | 4 | Byte enables for the write |
| host_wdata | input | 32 | Write data |
| host_rsel | input | 1 | Read select: 0 low word, 1 high word |
| host_rdata | output | 32 | Read data of the selected word |
| cfg_big_endian | input | 1 | Static trigger byte select: 0 uses byte 3, 1 uses byte 0 |
| tx_src_addr | output | 48 | Station address in the host domain |
| rclk | input | 1 | Receive clock |
| rrst_n | input | 1 | Receive domain reset, active low |
| rx_valid | input | 1 | Receive byte valid |
| rx_ready | output | 1 | Receive byte accepted (always high) |
| rx_sof | input | 1 | Marks the first destination byte |
| rx_data | input | 8 | Receive byte |
| rx_match | output | 1 | One-cycle destination match pulse |

## Verification
The bench builds the block with its default two-flop synchronizer. It runs the host at 250 MHz and gives the receive side an unrelated 6 ns clock, so the request toggle really crosses between asynchronous clocks. The address width is fixed at six bytes, so every byte position of the compare can be reached, including a single flipped bit in each lane. Both endianness settings are exercised, together with trigger and non-trigger byte enables.

// File: rtl/sta_pkg.sv
package sta_pkg;
  localparam int ADDR_BYTES = 6;
  localparam int ADDR_W     = 8 * ADDR_BYTES;
  localparam int WORD_W     = 32;
  localparam int HI_W       = ADDR_W - WORD_W;

  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/sta_host_regs.sv
module sta_host_regs
  import sta_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic              sel,
  input  logic [3:0]        be,
  input  logic [WORD_W-1:0] wdata,
  input  logic              big_endian,
  input  logic              rsel,
  output logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] addr_o,
  output logic [ADDR_W-1:0] snap_o,
  output logic              req_tog_o
);
  localparam int LO_LANES = WORD_W / 8;
  localparam int HI_LANES = HI_W / 8;

  logic [WORD_W-1:0] lo_q, lo_nxt;
  logic [HI_W-1:0]   hi_q, hi_nxt;
  logic [ADDR_W-1:0] snap_q;
  logic              tog_q;
  logic              lo_wr, hi_wr, trig;

  assign lo_wr = wr && (sel == SEL_LOW);
  assign hi_wr = wr && (sel == SEL_HIGH);
  assign trig  = lo_wr && (big_endian ? be[0] : be[LO_LANES-1]);

  for (genvar i = 0; i < LO_LANES; i++) begin : g_lo_lane
    assign lo_nxt[8*i +: 8] = (lo_wr && be[i]) ? wdata[8*i +: 8] : lo_q[8*i +: 8];
  end

  for (genvar j = 0; j < HI_LANES; j++) begin : g_hi_lane
    assign hi_nxt[8*j +: 8] = (hi_wr && be[j]) ? wdata[8*j +: 8] : hi_q[8*j +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q   <= '1;
      hi_q   <= '1;
      snap_q <= '1;
      tog_q  <= 1'b0;
    end else begin
      lo_q <= lo_nxt;
      hi_q <= hi_nxt;
      if (trig) begin
        snap_q <= {hi_nxt, lo_nxt};
        tog_q  <= ~tog_q;
      end
    end
  end

  assign rdata     = (rsel == SEL_HIGH) ? {1'b1, {(WORD_W-HI_W-1){1'b0}}, hi_q} : lo_q;
  assign addr_o    = {hi_q, lo_q};
  assign snap_o    = snap_q;
  assign req_tog_o = tog_q;

  AST_LOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(lo_q) && $stable(hi_q)); // R1
  AST_TRIG_ONLY_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == SEL_LOW && (big_endian ? be[0] : be[3])) |=> $stable(tog_q)); // R5
endmodule

// File: rtl/sta_cdc_capture.sv
module sta_cdc_capture
  import sta_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tog_i,
  input  logic [ADDR_W-1:0] snap_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [SYNC_STAGES:0] sync_q;
  logic [ADDR_W-1:0]    addr_q;
  logic                 cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[SYNC_STAGES-1:0], tog_i};
  end

  assign cap = sync_q[SYNC_STAGES] ^ sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   addr_q <= '1;
    else if (cap) addr_q <= snap_i;
  end

  assign addr_o = addr_q;

  AST_COPY_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(addr_q)); // R7
endmodule

// File: rtl/sta_rx_match.sv
module sta_rx_match
  import sta_pkg::*;
#(
  parameter int BYTES = ADDR_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [8*BYTES-1:0] addr_i,
  input  logic               valid,
  input  logic               sof,
  input  logic [7:0]         data,
  output logic               ready,
  output logic               match_o
);
  localparam int CW = $clog2(BYTES + 1);

  logic [CW-1:0] cnt_q;
  logic          eq_q, match_q, rdy_q;
  logic [7:0]    exp_byte;
  logic          hit;

  always_comb begin
    exp_byte = addr_i[7:0];
    for (int i = 0; i < BYTES; i++)
      if (cnt_q == CW'(i)) exp_byte = addr_i[8*i +: 8];
  end

  assign hit = (data == exp_byte);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CW'(BYTES);
      eq_q    <= 1'b0;
      match_q <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      rdy_q   <= 1'b1;
      match_q <= 1'b0;
      if (valid) begin
        if (sof) begin
          cnt_q <= CW'(1);
          eq_q  <= (data == addr_i[7:0]);
        end else if (cnt_q < CW'(BYTES)) begin
          cnt_q <= cnt_q + CW'(1);
          eq_q  <= eq_q & hit;
          if (cnt_q == CW'(BYTES-1)) match_q <= eq_q & hit;
        end
      end
    end
  end

  assign ready   = rdy_q;
  assign match_o = match_q;

  AST_MATCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |=> !match_q); // R8
  AST_MATCH_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    match_q |-> $past(valid && !sof)); // R8
  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> rdy_q); // R10
endmodule

// File: rtl/sta_addr_filter.sv
module sta_addr_filter
  import sta_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        hclk,
  input  logic        hrst_n,
  input  logic        host_wr,
  input  logic        host_sel,
  input  logic [3:0]  host_be,
  input  logic [31:0] host_wdata,
  input  logic        host_rsel,
  output logic [31:0] host_rdata,
  input  logic        cfg_big_endian,
  output logic [47:0] tx_src_addr,
  input  logic        rclk,
  input  logic        rrst_n,
  input  logic        rx_valid,
  output logic        rx_ready,
  input  logic        rx_sof,
  input  logic [7:0]  rx_data,
  output logic        rx_match
);
  logic [ADDR_W-1:0] snap;
  logic [ADDR_W-1:0] rx_addr;
  logic              req_tog;

  sta_host_regs u_regs (
    .clk        (hclk),
    .rst_n      (hrst_n),
    .wr         (host_wr),
    .sel        (host_sel),
    .be         (host_be),
    .wdata      (host_wdata),
    .big_endian (cfg_big_endian),
    .rsel       (host_rsel),
    .rdata      (host_rdata),
    .addr_o     (tx_src_addr),
    .snap_o     (snap),
    .req_tog_o  (req_tog)
  );

  sta_cdc_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cdc (
    .clk    (rclk),
    .rst_n  (rrst_n),
    .tog_i  (req_tog),
    .snap_i (snap),
    .addr_o (rx_addr)
  );

  sta_rx_match #(.BYTES(ADDR_BYTES)) u_match (
    .clk     (rclk),
    .rst_n   (rrst_n),
    .addr_i  (rx_addr),
    .valid   (rx_valid),
    .sof     (rx_sof),
    .data    (rx_data),
    .ready   (rx_ready),
    .match_o (rx_match)
  );
endmodule

// File: tb/sta_addr_filter_test.sv
module sta_addr_filter_test;
  logic        hclk = 1'b0, rclk = 1'b0;
  logic        hrst_n = 1'b0, rrst_n = 1'b0;
  logic        host_wr = 1'b0, host_sel = 1'b0, host_rsel = 1'b0;
  logic [3:0]  host_be = '0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        cfg_big_endian = 1'b0;
  logic [47:0] tx_src_addr;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic        rx_ready, rx_match;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] m_lo;
  logic [15:0] m_hi;
  logic [47:0] m_rx;

  always #2 hclk = ~hclk;
  always #3 rclk = ~rclk;

  sta_addr_filter uut (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] merge(input logic [31:0] old, input logic [3:0] be, input logic [31:0] d);
    logic [31:0] r = old;
    for (int b = 0; b < 4; b++) if (be[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  task automatic hwrite(input logic sel, input logic [3:0] be, input logic [31:0] d);
    @(negedge hclk);
    host_wr = 1'b1; host_sel = sel; host_be = be; host_wdata = d;
    @(negedge hclk);
    host_wr = 1'b0;
    if (sel == 1'b0) begin
      m_lo = merge(m_lo, be, d);
      if (cfg_big_endian ? be[0] : be[3]) m_rx = {m_hi, m_lo};
    end else begin
      m_hi = merge({16'h0, m_hi}, be & 4'b0011, d)[15:0];
    end
    repeat (8) @(negedge rclk);
  endtask

  task automatic hread(input logic sel, output logic [31:0] v);
    @(negedge hclk);
    host_rsel = sel;
    #1 v = host_rdata;
  endtask

  // sends bytes of a (LSB first) up to n; flip bit 0 of byte fl when fl < 6
  task automatic frame(input logic [47:0] a, input int n, input int fl, input bit exp, input string req);
    bit early = 0;
    logic m1, m2;
    for (int k = 0; k < n; k++) begin
      @(negedge rclk);
      if (rx_match) early = 1;
      rx_valid = 1'b1; rx_sof = (k == 0);
      rx_data = a[8*k +: 8] ^ ((k == fl) ? 8'h01 : 8'h00);
    end
    @(negedge rclk);
    rx_valid = 1'b0; rx_sof = 1'b0;
    m1 = rx_match;
    @(negedge rclk);
    m2 = rx_match;
    chk(!early && m1 == exp, req, {63'd0, m1}, {63'd0, exp});
    chk(m2 == 1'b0, "R8", {63'd0, m2}, 64'd0);
  endtask

  initial begin
    #2000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, lo, hi;
    logic [3:0] be;
    void'($urandom(32'h5EED));
    m_lo = '1; m_hi = '1; m_rx = '1;
    repeat (5) @(negedge hclk);
    hrst_n = 1'b1; rrst_n = 1'b1;
    repeat (4) @(negedge rclk);

    hread(1'b0, v); chk(v == 32'hFFFFFFFF, "R1", v, 32'hFFFFFFFF);
    hread(1'b1, v); chk(v == 32'h8000FFFF, "R2", v, 32'h8000FFFF);
    chk(tx_src_addr == '1, "R3", tx_src_addr, 48'hFFFFFFFFFFFF);
    chk(rx_ready == 1'b1, "R10", rx_ready, 1);
    frame(48'hFFFFFFFFFFFF, 6, 9, 1'b1, "R7");

    hwrite(1'b1, 4'b1111, 32'h7ABC1234);
    hread(1'b1, v); chk(v == 32'h80001234, "R2", v, 32'h80001234);
    chk(tx_src_addr == {16'h1234, 32'hFFFFFFFF}, "R3", tx_src_addr, {16'h1234, 32'hFFFFFFFF});
    frame(48'hFFFFFFFFFFFF, 6, 9, 1'b1, "R5");

    hwrite(1'b0, 4'b0111, 32'h00332211);
    hread(1'b0, v); chk(v == 32'hFF332211, "R1", v, 32'hFF332211);
    frame({16'h1234, 32'hFF332211}, 6, 9, 1'b0, "R5");
    frame(48'hFFFFFFFFFFFF, 6, 9, 1'b1, "R5");
    hwrite(1'b0, 4'b1000, 32'h44000000);
    chk(tx_src_addr == 48'h123444332211, "R3", tx_src_addr, 48'h123444332211);
    hwrite(1'b1, 4'b0011, 32'h00006655);
    frame(48'h123444332211, 6, 9, 1'b1, "R4");
    frame(48'h665544332211, 6, 9, 1'b0, "R5");
    hwrite(1'b0, 4'b1000, 32'h44000000);
    frame(48'h665544332211, 6, 9, 1'b1, "R4");

    frame(48'h665544332211, 3, 9, 1'b0, "R9");
    frame(48'h665544332211, 6, 9, 1'b1, "R9");
    for (int k = 0; k < 3; k++) begin
      @(negedge rclk); rx_valid = 1'b1; rx_sof = 1'b0; rx_data = 8'h55;
      @(negedge rclk); rx_valid = 1'b0;
      chk(rx_match == 1'b0, "R9", rx_match, 0);
    end
    for (int k = 0; k < 6; k++) frame(48'h665544332211, 6, k, 1'b0, "R8");

    cfg_big_endian = 1'b1;
    hwrite(1'b0, 4'b1110, 32'hA1B2C300);
    frame(48'h665544332211, 6, 9, 1'b1, "R6");
    hwrite(1'b0, 4'b0001, 32'h000000D4);
    frame(48'h6655A1B2C3D4, 6, 9, 1'b1, "R6");

    for (int i = 0; i < 30; i++) begin
      cfg_big_endian = (i >= 15);
      hi = $urandom; lo = $urandom; be = 4'($urandom);
      hwrite(1'b1, 4'b0011, hi);
      hwrite(1'b0, be, lo);
      hwrite(1'b0, cfg_big_endian ? 4'b0001 : 4'b1000, $urandom);
      chk(tx_src_addr == {m_hi, m_lo}, "R3", tx_src_addr, {m_hi, m_lo});
      frame(m_rx, 6, 9, 1'b1, "R7");
      frame(m_rx, 6, int'($urandom % 6), 1'b0, "R8");
    end

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule